// File: doc/BRIEF.md
# SDRAM Full-Page Write Sequencer

This block runs one write burst into a synchronous DRAM with the device in full-page burst mode. A request gives a bank, a row, a starting column and a word count. The block opens the row, waits the row-to-column delay, and issues a write at the starting column. It then streams one word per clock from a valid/ready source. A full-page burst does not end on its own, so the block counts the words and ends the burst with an explicit terminate command. The column index wraps inside the row: a burst that starts at column m and covers the whole page finishes at column m-1.

The row stays open after the burst, and no precharge is issued. A write-recovery counter starts at the terminate. A status flag reports when a later precharge would be legal, and the block takes no new request before that flag is high. Every pin toward the memory comes straight from a flip-flop, so the pins change only at the rising clock edge. A request with a zero count, or with a count larger than one page, is refused with a one-cycle error pulse and produces no command.

Top module: `sdram_fpw_seq`

## Requirements
- R1: After reset, the command pins show NOP, dq_oe is 0, dqm is 1, req_ready and pre_ok are 1, and done and err are 0.
- R2: In the cycle after an accepted request with a legal count, the command pins show ACTIVE. ba carries the bank and addr carries the full row (A10 is a row bit here).
- R3: WRITE appears exactly T_RCD cycles after ACTIVE, with only NOPs in between. During WRITE, ba carries the bank and addr[COL_W-1:0] carries the start column. All higher address bits are 0, so A10 (the auto-precharge bit) is low.
- R4: The burst occupies cycles W to W+len-1, where W is the WRITE cycle. dq_oe is high in exactly those cycles. Word k is driven in cycle W+k. wr_ready is high in the cycle before each of these beats and in no other cycle.
- R5: If wr_valid is low when a beat is launched, dqm is high for that beat, and the beat still counts toward len. The burst is not extended. When dq_oe is low, dqm is high.
- R6: BURST TERMINATE appears in cycle W+len. done is high in that cycle and in no other, and in that cycle dq_oe is 0 and dqm is 1.
- R7: The command pins {cs_n, ras_n, cas_n, we_n} only ever carry NOP=0111, ACTIVE=0011, WRITE=0100 or BURST TERMINATE=0110. After the terminate, only NOP follows, and no precharge is ever issued.
- R8: A request with len equal to 0 or greater than 2^COL_W gives err high for one cycle, in the cycle after the request. No command or data is issued for it, and req_ready stays high.
- R9: pre_ok and req_ready fall in the ACTIVE cycle. They rise together exactly T_WR cycles after the terminate cycle, and a new request can be accepted in that cycle.
- R10: A burst may cross the end of the row. When the burst ends, the internal column tracker equals (start + len - 1) mod 2^COL_W. A full-page request (len = 2^COL_W) gives exactly 2^COL_W beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and recovered; request accepted when both are high |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Start column |
| req_len | input | COL_W+1 | Number of words, 1 to 2^COL_W |
| err | output | 1 | One-cycle pulse: request refused |
| done | output | 1 | One-cycle pulse in the terminate cycle |
| pre_ok | output | 1 | Write recovery elapsed; precharge would be legal |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Next clock edge launches a burst beat |
| wr_data | input | DATA_W | Write word |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row or column address |
| dq_out | output | DATA_W | Data toward the memory |
| dq_oe | output | 1 | Data output enable |
| dqm | output | 1 | Data mask, high masks the column |

## Verification
A beat counter that is off by one changes how many cycles dq_oe is high. It also moves the terminate, which shows as done arriving one cycle early or late relative to WRITE, within the same burst. A wrong row-to-column counter shifts WRITE relative to ACTIVE, and a slip in the data path shows as dqm or dq_out disagreeing with the word offered for that beat in the same cycle. A recovery counter fault is visible a few cycles after the terminate, as pre_ok and req_ready rising at the wrong time. A length-check fault is visible in the cycle after the request, as a missing err or a stray ACTIVE.

// File: rtl/sdram_fpw_pkg.sv
// Shared command codes and controller state encoding for the full-page
// write sequencer. Assumes the command pin order {cs_n, ras_n, cas_n, we_n}.
package sdram_fpw_pkg;

    typedef logic [3:0] cmd_t;

    localparam cmd_t CMD_NOP = 4'b0111;
    localparam cmd_t CMD_ACT = 4'b0011;
    localparam cmd_t CMD_WR  = 4'b0100;
    localparam cmd_t CMD_BST = 4'b0110;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RCD   = 2'd1,
        ST_BURST = 2'd2,
        ST_RECOV = 2'd3
    } seq_st_e;

endpackage

// File: rtl/sdram_fpw_lencheck.sv
// Word-count screen: flags a count as legal when it lies between one word
// and a full page inclusive. Purely combinational.
// Assumes LEN_W is wide enough to hold PAGE.
module sdram_fpw_lencheck #(
    parameter int LEN_W = 10,
    parameter int PAGE  = 512
) (
    input  logic [LEN_W-1:0] len,
    output logic             ok
);

    localparam logic [LEN_W-1:0] PAGE_V = LEN_W'(PAGE);

    // legal when non-zero and no larger than one page
    always_comb ok = (len != '0) && (len <= PAGE_V);

endmodule

// File: rtl/sdram_fpw_delay.sv
// Loadable down counter used for the row-to-column wait and the write
// recovery wait. Holds at zero once expired.
// Assumes load has priority over the countdown.
module sdram_fpw_delay #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // load a new delay or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sdram_fpw_beats.sv
// Burst progress tracker: remaining-beat count and the column of the most
// recently launched beat. The column register is COL_W bits wide, so it
// wraps to zero past the last column of the row.
// Assumes load and step are never high together.
module sdram_fpw_beats #(
    parameter int COL_W = 9,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] start_col,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] left_o,
    output logic [COL_W-1:0] col_o
);

    logic [LEN_W-1:0] left_q;
    logic [COL_W-1:0] col_q;

    // first beat loads the tracker, each later beat advances it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            col_q  <= '0;
        end else if (load) begin
            left_q <= len - LEN_W'(1);
            col_q  <= start_col;
        end else if (step) begin
            left_q <= left_q - LEN_W'(1);
            col_q  <= col_q + COL_W'(1);
        end
    end

    assign left_o = left_q;
    assign col_o  = col_q;

endmodule

// File: rtl/sdram_fpw_seq.sv
// Full-page write sequencer. Opens a row, waits T_RCD clocks, writes len
// words starting at the requested column, and ends the burst with a
// terminate command. The row is left open, and pre_ok reports when write
// recovery (T_WR clocks after the terminate) has elapsed.
// Assumes: memory set to full-page burst length; COL_W <= 10 so the column
// never reaches A10; ROW_W <= ADDR_W; T_RCD >= 1 and T_WR >= 1.
// All memory-side outputs and handshake outputs are registered.
module sdram_fpw_seq
    import sdram_fpw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BA_W   = 2,
    parameter int ROW_W  = 12,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int T_RCD  = 2,
    parameter int T_WR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W:0]    req_len,
    output logic              err,
    output logic              done,
    output logic              pre_ok,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dqm
);

    localparam int PAGE    = 1 << COL_W;
    localparam int LEN_W   = COL_W + 1;
    localparam int TMR_MAX = (T_RCD > T_WR) ? T_RCD : T_WR;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    // registered state and outputs
    seq_st_e            st_q;
    cmd_t               cmd_q;
    logic [BA_W-1:0]    ba_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  dq_q;
    logic               oe_q;
    logic               dqm_q;
    logic               wrdy_q;
    logic               rrdy_q;
    logic               pok_q;
    logic               done_q;
    logic               err_q;

    // request fields held for the life of the burst
    logic [BA_W-1:0]    bank_hold_q;
    logic [COL_W-1:0]   col_hold_q;
    logic [LEN_W-1:0]   len_hold_q;

    // helper wires
    logic               len_ok;
    logic [TMR_W-1:0]   rcd_cnt;
    logic [TMR_W-1:0]   wr_cnt;
    logic [LEN_W-1:0]   beats_left;
    logic [COL_W-1:0]   col_q;
    logic [ADDR_W-1:0]  col_addr;
    logic               accept;
    logic               start;
    logic               rcd_done;
    logic               rcd_last;
    logic               launch_first;
    logic               launch_next;
    logic               finish;
    logic               rec_done;

    sdram_fpw_lencheck #(
        .LEN_W (LEN_W),
        .PAGE  (PAGE)
    ) u_len (
        .len (req_len),
        .ok  (len_ok)
    );

    sdram_fpw_delay #(
        .W (TMR_W)
    ) u_rcd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (TMR_W'(T_RCD - 1)),
        .cnt_o    (rcd_cnt)
    );

    sdram_fpw_delay #(
        .W (TMR_W)
    ) u_wrec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (finish),
        .load_val (TMR_W'(T_WR - 1)),
        .cnt_o    (wr_cnt)
    );

    sdram_fpw_beats #(
        .COL_W (COL_W),
        .LEN_W (LEN_W)
    ) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch_first),
        .step      (launch_next),
        .start_col (col_hold_q),
        .len       (len_hold_q),
        .left_o    (beats_left),
        .col_o     (col_q)
    );

    // column phase address: start column in the low bits, rest held at zero
    generate
        if (ADDR_W > COL_W) begin : g_col_pad
            assign col_addr = {{(ADDR_W - COL_W){1'b0}}, col_hold_q};
        end else begin : g_col_trunc
            assign col_addr = col_hold_q[ADDR_W-1:0];
        end
    endgenerate

    // per-cycle control decisions taken from the current state
    always_comb begin
        accept       = (st_q == ST_IDLE) && rrdy_q && req_valid;
        start        = accept && len_ok;
        rcd_done     = (rcd_cnt == '0);
        rcd_last     = (rcd_cnt == TMR_W'(1));
        launch_first = (st_q == ST_RCD) && rcd_done;
        launch_next  = (st_q == ST_BURST) && (beats_left != '0);
        finish       = (st_q == ST_BURST) && (beats_left == '0);
        rec_done     = (st_q == ST_RECOV) && (wr_cnt == '0);
    end

    // sequencing state and command/address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cmd_q       <= CMD_NOP;
            ba_q        <= '0;
            addr_q      <= '0;
            rrdy_q      <= 1'b1;
            pok_q       <= 1'b1;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            wrdy_q      <= 1'b0;
            bank_hold_q <= '0;
            col_hold_q  <= '0;
            len_hold_q  <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q       <= CMD_ACT;
                        ba_q        <= req_bank;
                        addr_q      <= ADDR_W'(req_row);
                        bank_hold_q <= req_bank;
                        col_hold_q  <= req_col;
                        len_hold_q  <= req_len;
                        rrdy_q      <= 1'b0;
                        pok_q       <= 1'b0;
                        wrdy_q      <= (T_RCD == 1);
                        st_q        <= ST_RCD;
                    end else if (accept) begin
                        err_q <= 1'b1;
                    end
                end
                ST_RCD: begin
                    if (rcd_done) begin
                        cmd_q  <= CMD_WR;
                        ba_q   <= bank_hold_q;
                        addr_q <= col_addr;
                        wrdy_q <= (len_hold_q > LEN_W'(1));
                        st_q   <= ST_BURST;
                    end else begin
                        wrdy_q <= rcd_last;
                    end
                end
                ST_BURST: begin
                    if (finish) begin
                        cmd_q  <= CMD_BST;
                        done_q <= 1'b1;
                        wrdy_q <= 1'b0;
                        st_q   <= ST_RECOV;
                    end else begin
                        wrdy_q <= (beats_left > LEN_W'(1));
                    end
                end
                ST_RECOV: begin
                    if (rec_done) begin
                        pok_q  <= 1'b1;
                        rrdy_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // data pins: drive each launched beat, mask it when no word was offered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q  <= '0;
            oe_q  <= 1'b0;
            dqm_q <= 1'b1;
        end else if (launch_first || launch_next) begin
            oe_q  <= 1'b1;
            dqm_q <= !wr_valid;
            if (wr_valid) begin
                dq_q <= wr_data;
            end
        end else begin
            oe_q  <= 1'b0;
            dqm_q <= 1'b1;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign dq_out    = dq_q;
    assign dq_oe     = oe_q;
    assign dqm       = dqm_q;
    assign wr_ready  = wrdy_q;
    assign req_ready = rrdy_q;
    assign pre_ok    = pok_q;
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/sdram_fpw_seq_chk.sv
// Protocol checker for the full-page write sequencer. Keeps its own model
// of the accepted request and of the cycle distances between commands, and
// checks the pins against it. Attached to every instance by bind.
module sdram_fpw_seq_chk
    import sdram_fpw_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 12,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int T_RCD  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BA_W-1:0]   req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic [COL_W-1:0]  req_col,
    input logic [COL_W:0]    req_len,
    input logic [3:0]        cmd,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic              dqm,
    input logic              done,
    input logic              err,
    input logic              pre_ok,
    input logic [COL_W-1:0]  col_trk
);

    localparam int LEN_W = COL_W + 1;
    localparam int PAGE  = 1 << COL_W;

    logic              good_len;
    logic              acc;
    logic [LEN_W-1:0]  end_sum;
    logic              acc_q;
    logic [BA_W-1:0]   bank_m;
    logic [ROW_W-1:0]  row_m;
    logic [COL_W-1:0]  col_m;
    logic [LEN_W-1:0]  len_m;
    logic [COL_W-1:0]  end_m;
    logic [LEN_W-1:0]  beat_m;
    logic [15:0]       since_act;

    // checker's own view of an accepted request and its expected end column
    always_comb begin
        good_len = (req_len != '0) && (req_len <= LEN_W'(PAGE));
        acc      = req_valid && req_ready && good_len;
        end_sum  = {1'b0, req_col} + req_len - LEN_W'(1);
    end

    // request capture, beat counting and distance from the last ACTIVE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= 1'b0;
            bank_m    <= '0;
            row_m     <= '0;
            col_m     <= '0;
            len_m     <= '0;
            end_m     <= '0;
            beat_m    <= '0;
            since_act <= 16'hFFFF;
        end else begin
            acc_q <= acc;
            if (acc) begin
                bank_m <= req_bank;
                row_m  <= req_row;
                col_m  <= req_col;
                len_m  <= req_len;
                end_m  <= end_sum[COL_W-1:0];
                beat_m <= '0;
            end else if (dq_oe) begin
                beat_m <= beat_m + LEN_W'(1);
            end
            if (cmd == CMD_ACT) begin
                since_act <= 16'd1;
            end else if (since_act != 16'hFFFF) begin
                since_act <= since_act + 16'd1;
            end
        end
    end

    AST_ACT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> (cmd == CMD_ACT && ba == bank_m && addr == ADDR_W'(row_m))); // R2
    AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |-> (since_act == 16'(T_RCD))); // R3
    AST_WRITE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |-> (addr == ADDR_W'(col_m) && ba == bank_m)); // R3
    AST_OE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (beat_m < len_m)); // R4
    AST_MASK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dqm); // R5
    AST_BST_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST) |-> (beat_m == len_m && done)); // R6
    AST_DONE_ONLY_BST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_BST && !dq_oe)); // R6
    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_ACT || cmd == CMD_WR || cmd == CMD_BST)); // R7
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cmd == CMD_NOP && !dq_oe && req_ready)); // R8
    AST_READY_RECOVERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> pre_ok); // R9
    AST_ACT_BLOCKS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !pre_ok); // R9
    AST_COL_WRAP_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (col_trk == end_m)); // R10

endmodule

bind sdram_fpw_seq sdram_fpw_seq_chk #(
    .BA_W   (BA_W),
    .ROW_W  (ROW_W),
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .T_RCD  (T_RCD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_len   (req_len),
    .cmd       ({cs_n, ras_n, cas_n, we_n}),
    .ba        (ba),
    .addr      (addr),
    .dq_oe     (dq_oe),
    .dqm       (dqm),
    .done      (done),
    .err       (err),
    .pre_ok    (pre_ok),
    .col_trk   (col_q)
);

// File: tb/sdram_fpw_seq_tb.sv
module sdram_fpw_seq_tb;

    localparam int DATA_W = 16;
    localparam int BA_W   = 2;
    localparam int ROW_W  = 12;
    localparam int ADDR_W = 12;
    localparam int COL_W  = 9;
    localparam int T_RCD  = 2;
    localparam int T_WR   = 2;
    localparam int PAGE   = 1 << COL_W;
    localparam int LEN_W  = COL_W + 1;

    localparam logic [3:0] E_NOP = 4'b0111;
    localparam logic [3:0] E_ACT = 4'b0011;
    localparam logic [3:0] E_WR  = 4'b0100;
    localparam logic [3:0] E_BST = 4'b0110;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BA_W-1:0]   req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              err;
    logic              done;
    logic              pre_ok;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [DATA_W-1:0] wr_data = '0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    logic              dqm;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [DATA_W-1:0] sent_d [0:PAGE-1];
    bit                sent_v [0:PAGE-1];

    always #2 clk = ~clk;

    sdram_fpw_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .err(err), .done(done), .pre_ok(pre_ok),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input int t, input int len);
        if (t == 0) return E_ACT;
        if (t == T_RCD) return E_WR;
        if (t == T_RCD + len) return E_BST;
        return E_NOP;
    endfunction

    function automatic logic [ADDR_W-1:0] col_pins(input logic [COL_W-1:0] c);
        return ADDR_W'(c);
    endfunction

    // vmode: 0 all words offered, 1 random gaps, 2 no words offered
    task automatic run_burst(input logic [BA_W-1:0] b, input logic [ROW_W-1:0] r,
                             input logic [COL_W-1:0] c, input int len, input int vmode);
        int fin;
        logic [3:0] cmd_now;
        fin = T_RCD + len + T_WR;
        chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
        req_bank  = b;
        req_row   = r;
        req_col   = c;
        req_len   = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t <= fin; t++) begin
            cmd_now = {cs_n, ras_n, cas_n, we_n};
            if (t == 0) begin
                chk(cmd_now == E_ACT, "R2 ACTIVE cmd", cmd_now, E_ACT);
                chk(ba == b, "R2 ACTIVE bank", ba, b);
                chk(addr == ADDR_W'(r), "R2 ACTIVE row", addr, r);
            end else if (t == T_RCD) begin
                chk(cmd_now == E_WR, "R3 WRITE cmd", cmd_now, E_WR);
                chk(ba == b, "R3 WRITE bank", ba, b);
                chk(addr == col_pins(c), "R3 WRITE column", addr, col_pins(c));
            end else if (t == T_RCD + len) begin
                chk(cmd_now == E_BST, "R6 terminate cmd", cmd_now, E_BST);
            end else begin
                chk(cmd_now == exp_cmd(t, len), "R7 NOP between commands", cmd_now, exp_cmd(t, len));
            end
            chk(done == (t == T_RCD + len), "R6 done pulse", done, (t == T_RCD + len));
            chk(wr_ready == (t >= T_RCD - 1 && t <= T_RCD + len - 2), "R4 wr_ready window",
                wr_ready, (t >= T_RCD - 1 && t <= T_RCD + len - 2));
            chk(pre_ok == (t == fin), "R9 pre_ok timing", pre_ok, (t == fin));
            chk(req_ready == (t == fin), "R9 req_ready timing", req_ready, (t == fin));
            if (t >= T_RCD && t < T_RCD + len) begin
                chk(dq_oe == 1'b1, "R4 dq_oe during burst", dq_oe, 1);
                chk(dqm == !sent_v[t - T_RCD], "R5 dqm follows offered word", dqm, !sent_v[t - T_RCD]);
                if (sent_v[t - T_RCD])
                    chk(dq_out == sent_d[t - T_RCD], "R4 beat data", dq_out, sent_d[t - T_RCD]);
            end else begin
                chk(dq_oe == 1'b0 && dqm == 1'b1, "R6 pins quiet outside burst", {dq_oe, dqm}, 2'b01);
            end
            if (wr_ready) begin
                wr_valid = (vmode == 0) ? 1'b1 : (vmode == 2) ? 1'b0 : (($urandom % 4) != 0);
                wr_data  = DATA_W'($urandom);
                sent_v[t + 1 - T_RCD] = wr_valid;
                sent_d[t + 1 - T_RCD] = wr_data;
            end else begin
                wr_valid = 1'b0;
            end
            if (t < fin) @(negedge clk);
        end
    endtask

    task automatic bad_request(input int len);
        req_len   = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R8 err pulse", err, 1);
        chk({cs_n, ras_n, cas_n, we_n} == E_NOP, "R8 no command on refusal", {cs_n, ras_n, cas_n, we_n}, E_NOP);
        chk(req_ready == 1'b1 && dq_oe == 1'b0, "R8 stays ready", {req_ready, dq_oe}, 2'b10);
        @(negedge clk);
        chk(err == 1'b0, "R8 err one cycle", err, 0);
        chk({cs_n, ras_n, cas_n, we_n} == E_NOP, "R8 still no command", {cs_n, ras_n, cas_n, we_n}, E_NOP);
        chk(pre_ok == 1'b1, "R8 pre_ok unaffected", pre_ok, 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({cs_n, ras_n, cas_n, we_n} == E_NOP, "R1 reset cmd", {cs_n, ras_n, cas_n, we_n}, E_NOP);
        chk(dq_oe == 1'b0 && dqm == 1'b1, "R1 reset data pins", {dq_oe, dqm}, 2'b01);
        chk(req_ready && pre_ok, "R1 reset ready flags", {req_ready, pre_ok}, 2'b11);
        chk(!done && !err && !wr_ready, "R1 reset pulses", {done, err, wr_ready}, 3'b000);

        // directed corners
        run_burst(2'd1, 12'h5A5, 9'd7, 1, 0);
        run_burst(2'd3, 12'hFFF, 9'd100, 2, 0);
        run_burst(2'd0, 12'h400, 9'd300, PAGE, 0);         // R10 full page with wrap
        run_burst(2'd2, 12'h123, 9'd0, PAGE, 1);           // R10 full page, gaps
        run_burst(2'd1, 12'h0F0, 9'(PAGE - 1), PAGE - 1, 0); // R10 wrap at last column
        run_burst(2'd2, 12'h0AA, 9'(PAGE - 3), 8, 2);      // R5 all masked across wrap
        bad_request(0);
        bad_request(PAGE + 1);
        bad_request((1 << LEN_W) - 1);

        // constrained random bursts, back to back
        for (int i = 0; i < 30; i++) begin
            run_burst(BA_W'($urandom), ROW_W'($urandom), COL_W'($urandom),
                      1 + int'($urandom % 40), int'($urandom % 2));
            if (($urandom % 5) == 0) bad_request(0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule